// File: doc/BRIEF.md
# Bridge Address Window Decoder

This block decides, for every downstream request that reaches a PCI-to-PCI bridge, whether the bridge claims it and passes it to the secondary bus. It takes the packed base and limit fields of the bridge's type-1 configuration header as they are stored. From them it rebuilds the bounds of three windows: I/O, non-prefetchable memory and prefetchable memory. Each window has its own granularity, and the I/O and prefetchable windows can optionally take extra upper address bits.

Each window is gated by its command-register enable. A window whose limit is below its base matches nothing. A separate fixed path claims the legacy VGA memory and I/O ranges whenever the bridge-control VGA enable is set, whatever the windows hold. The decision is registered. It is reported one clock after the request, together with a code naming the window that claimed it. Configuration access decoding and the transport of the transaction itself belong to other blocks.

Top module: `bridge_window_decoder`

## Requirements
- R1: While reset is asserted and on the first cycle after it, dec_valid and dec_fwd are 0 and dec_win is 0.
- R2: A request presented with req_valid high at one clock edge gives dec_valid high on the next cycle. When req_valid was low, dec_valid and dec_fwd are 0 and dec_win is 0. dec_fwd is never high without dec_valid.
- R3: The I/O window lower bound is io_base_fld[7:4] placed at address bits 15:12 with bits 11:0 zero. The upper bound is io_limit_fld[7:4] at bits 15:12 with bits 11:0 all ones. When bit 0 of a field is 0, address bits 31:16 of that bound are zero and the matching upper-16 input is ignored.
- R4: When bit 0 of io_base_fld or io_limit_fld is 1, io_base_hi or io_limit_hi supplies bits 31:16 of that bound. I/O requests with any address bit above 31 set never match the I/O window.
- R5: The non-prefetchable memory window runs from mem_base_fld[15:4] at bits 31:20 (low 20 bits zero) to mem_limit_fld[15:4] at bits 31:20 (low 20 bits one). Requests with any bit above 31 set miss it.
- R6: The prefetchable window is built like the memory window from pf_base_fld and pf_limit_fld. When bit 0 of a field is 1, pf_base_hi or pf_limit_hi supplies address bits 63:32 of that bound; otherwise those bits are zero.
- R7: A window whose rebuilt limit is below its rebuilt base is empty and matches no address.
- R8: cmd_word bit 0 enables the I/O window. cmd_word bit 1 enables both memory windows. A window whose enable is clear never forwards.
- R9: When brctl_word bit 3 is set, memory requests in 0xA0000–0xBFFFF and I/O requests in 0x3B0–0x3BB or 0x3C0–0x3DF are forwarded, independent of the windows and of cmd_word. I/O 0x3BC–0x3BF is not a VGA address. With bit 3 clear, these ranges get no special treatment.
- R10: Priority when several paths match: VGA, then prefetchable, then non-prefetchable for memory; VGA, then the I/O window for I/O.
- R11: req_space encodes 0 = I/O, 1 = memory, 2 = prefetchable memory, 3 = reserved. Codes 1 and 2 both consult both memory windows. Code 0 consults only the I/O window and VGA I/O ranges. Code 3 never forwards.
- R12: dec_win encodes 0 = none, 1 = I/O window, 2 = memory window, 3 = prefetchable window, 4 = VGA. dec_fwd is 1 exactly when dec_win is not 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_space | input | 2 | Request address space code |
| req_addr | input | 64 | Request address |
| cmd_word | input | 16 | Command register (bit 0 I/O enable, bit 1 memory enable) |
| brctl_word | input | 16 | Bridge control register (bit 3 VGA enable) |
| io_base_fld | input | 8 | I/O base field |
| io_limit_fld | input | 8 | I/O limit field |
| io_base_hi | input | 16 | I/O base upper 16 bits |
| io_limit_hi | input | 16 | I/O limit upper 16 bits |
| mem_base_fld | input | 16 | Memory base field |
| mem_limit_fld | input | 16 | Memory limit field |
| pf_base_fld | input | 16 | Prefetchable base field |
| pf_limit_fld | input | 16 | Prefetchable limit field |
| pf_base_hi | input | 32 | Prefetchable base upper 32 bits |
| pf_limit_hi | input | 32 | Prefetchable limit upper 32 bits |
| dec_valid | output | 1 | Decision present |
| dec_fwd | output | 1 | Forward to secondary side |
| dec_win | output | 3 | Claiming window code |

## Verification
The properties check, on every cycle, that a decision appears one cycle after each request. They also check that the window code claimed matches the enable or VGA bit sampled with that request, that I/O claims come only from I/O requests, and that reserved requests are never forwarded. The exact window edges cannot be shown by a property. Only the directed scenarios show them: the 4 KiB and 1 MiB granularity, the effect of the upper-address type bits, empty windows, the VGA range boundaries such as the gap at 0x3BC, and the priority order.

// File: rtl/bwd_pkg.sv
package bwd_pkg;

    typedef enum logic [1:0] {
        SP_IO   = 2'd0,
        SP_MEM  = 2'd1,
        SP_PREF = 2'd2,
        SP_RSVD = 2'd3
    } space_e;

    typedef enum logic [2:0] {
        WIN_NONE = 3'd0,
        WIN_IO   = 3'd1,
        WIN_MEM  = 3'd2,
        WIN_PREF = 3'd3,
        WIN_VGA  = 3'd4
    } win_e;

    // bit positions of control fields consumed by this block
    localparam int CMD_IO_BIT    = 0;
    localparam int CMD_MEM_BIT   = 1;
    localparam int BRCTL_VGA_BIT = 3;

    // fixed legacy display ranges
    localparam logic [63:0] VGA_MEM_LO  = 64'h0000_0000_000A_0000;
    localparam logic [63:0] VGA_MEM_HI  = 64'h0000_0000_000B_FFFF;
    localparam logic [63:0] VGA_IOA_LO  = 64'h0000_0000_0000_03B0;
    localparam logic [63:0] VGA_IOA_HI  = 64'h0000_0000_0000_03BB;
    localparam logic [63:0] VGA_IOB_LO  = 64'h0000_0000_0000_03C0;
    localparam logic [63:0] VGA_IOB_HI  = 64'h0000_0000_0000_03DF;

    typedef struct packed {
        logic valid;
        logic fwd;
        win_e win;
    } dec_s;

endpackage

// File: rtl/bwd_window.sv
module bwd_window #(
    parameter int ADDR_W    = 64,
    parameter int FIELD_W   = 16,
    parameter int GRAN_BITS = 20,
    parameter int HI_W      = 32,
    parameter bit HAS_HI    = 1'b1
) (
    input  logic [FIELD_W-1:0] base_fld,
    input  logic [FIELD_W-1:0] limit_fld,
    input  logic [HI_W-1:0]    base_hi,
    input  logic [HI_W-1:0]    limit_hi,
    input  logic               enable,
    input  logic [ADDR_W-1:0]  addr,
    output logic               hit,
    output logic               empty
);
    localparam int NIB_W  = FIELD_W - 4;
    localparam int FULL_W = HI_W + NIB_W + GRAN_BITS;

    logic [HI_W-1:0]   base_upper;
    logic [HI_W-1:0]   limit_upper;
    logic [FULL_W-1:0] base_full;
    logic [FULL_W-1:0] limit_full;
    logic [ADDR_W-1:0] base_addr;
    logic [ADDR_W-1:0] limit_addr;

    generate
        if (HAS_HI) begin : g_ext
            // type bit 0 selects the extended addressing form
            assign base_upper  = base_fld[0]  ? base_hi  : '0;
            assign limit_upper = limit_fld[0] ? limit_hi : '0;
            logic unused_ext;
            assign unused_ext = ^{base_fld[3:1], limit_fld[3:1]};
        end else begin : g_flat
            assign base_upper  = '0;
            assign limit_upper = '0;
            logic unused_flat;
            assign unused_flat = ^{base_fld[3:0], limit_fld[3:0], base_hi, limit_hi};
        end
    endgenerate

    assign base_full  = {base_upper,  base_fld[FIELD_W-1:4],  {GRAN_BITS{1'b0}}};
    assign limit_full = {limit_upper, limit_fld[FIELD_W-1:4], {GRAN_BITS{1'b1}}};
    assign base_addr  = ADDR_W'(base_full);
    assign limit_addr = ADDR_W'(limit_full);

    always_comb begin
        empty = (limit_addr < base_addr);
        hit   = enable && !empty && (addr >= base_addr) && (addr <= limit_addr);
    end

endmodule

// File: rtl/bwd_vga_match.sv
module bwd_vga_match
    import bwd_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic              vga_en,
    input  logic [ADDR_W-1:0] addr,
    output logic              mem_hit,
    output logic              io_hit
);
    logic [63:0] a64;
    assign a64 = 64'(addr);

    always_comb begin
        mem_hit = vga_en && (a64 >= VGA_MEM_LO) && (a64 <= VGA_MEM_HI);
        io_hit  = vga_en && (((a64 >= VGA_IOA_LO) && (a64 <= VGA_IOA_HI)) ||
                             ((a64 >= VGA_IOB_LO) && (a64 <= VGA_IOB_HI)));
    end

endmodule

// File: rtl/bridge_window_decoder.sv
module bridge_window_decoder
    import bwd_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_space,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [15:0]       cmd_word,
    input  logic [15:0]       brctl_word,
    input  logic [7:0]        io_base_fld,
    input  logic [7:0]        io_limit_fld,
    input  logic [15:0]       io_base_hi,
    input  logic [15:0]       io_limit_hi,
    input  logic [15:0]       mem_base_fld,
    input  logic [15:0]       mem_limit_fld,
    input  logic [15:0]       pf_base_fld,
    input  logic [15:0]       pf_limit_fld,
    input  logic [31:0]       pf_base_hi,
    input  logic [31:0]       pf_limit_hi,
    output logic              dec_valid,
    output logic              dec_fwd,
    output logic [2:0]        dec_win
);
    localparam int IO_GRAN  = 12;
    localparam int MEM_GRAN = 20;

    logic io_hit, io_empty;
    logic mem_hit, mem_empty;
    logic pf_hit, pf_empty;
    logic vga_mem_hit, vga_io_hit;
    logic unused_top;

    assign unused_top = ^{io_empty, mem_empty, pf_empty,
                          cmd_word[15:2], brctl_word[15:4], brctl_word[2:0]};

    bwd_window #(
        .ADDR_W(ADDR_W), .FIELD_W(8), .GRAN_BITS(IO_GRAN), .HI_W(16), .HAS_HI(1'b1)
    ) io_win_i (
        .base_fld(io_base_fld), .limit_fld(io_limit_fld),
        .base_hi(io_base_hi), .limit_hi(io_limit_hi),
        .enable(cmd_word[CMD_IO_BIT]), .addr(req_addr),
        .hit(io_hit), .empty(io_empty)
    );

    bwd_window #(
        .ADDR_W(ADDR_W), .FIELD_W(16), .GRAN_BITS(MEM_GRAN), .HI_W(32), .HAS_HI(1'b0)
    ) mem_win_i (
        .base_fld(mem_base_fld), .limit_fld(mem_limit_fld),
        .base_hi('0), .limit_hi('0),
        .enable(cmd_word[CMD_MEM_BIT]), .addr(req_addr),
        .hit(mem_hit), .empty(mem_empty)
    );

    bwd_window #(
        .ADDR_W(ADDR_W), .FIELD_W(16), .GRAN_BITS(MEM_GRAN), .HI_W(32), .HAS_HI(1'b1)
    ) pf_win_i (
        .base_fld(pf_base_fld), .limit_fld(pf_limit_fld),
        .base_hi(pf_base_hi), .limit_hi(pf_limit_hi),
        .enable(cmd_word[CMD_MEM_BIT]), .addr(req_addr),
        .hit(pf_hit), .empty(pf_empty)
    );

    bwd_vga_match #(.ADDR_W(ADDR_W)) vga_i (
        .vga_en(brctl_word[BRCTL_VGA_BIT]), .addr(req_addr),
        .mem_hit(vga_mem_hit), .io_hit(vga_io_hit)
    );

    dec_s dec_d, dec_q;

    always_comb begin
        dec_d       = '0;
        dec_d.win   = WIN_NONE;
        dec_d.valid = req_valid;
        if (req_valid) begin
            unique case (space_e'(req_space))
                SP_IO: begin
                    if (vga_io_hit)  dec_d.win = WIN_VGA;
                    else if (io_hit) dec_d.win = WIN_IO;
                end
                SP_MEM, SP_PREF: begin
                    if (vga_mem_hit)  dec_d.win = WIN_VGA;
                    else if (pf_hit)  dec_d.win = WIN_PREF;
                    else if (mem_hit) dec_d.win = WIN_MEM;
                end
                default: dec_d.win = WIN_NONE;
            endcase
        end
        dec_d.fwd = (dec_d.win != WIN_NONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_q     <= '0;
            dec_q.win <= WIN_NONE;
        end else begin
            dec_q <= dec_d;
        end
    end

    assign dec_valid = dec_q.valid;
    assign dec_fwd   = dec_q.fwd;
    assign dec_win   = dec_q.win;

    // R2
    valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (dec_valid == $past(req_valid)));

    // R2
    fwd_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_fwd |-> dec_valid);

    // R8
    io_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_win == WIN_IO) |-> $past(cmd_word[CMD_IO_BIT]));

    // R8
    mem_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((dec_win == WIN_MEM) || (dec_win == WIN_PREF)) |-> $past(cmd_word[CMD_MEM_BIT]));

    // R9
    vga_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_win == WIN_VGA) |-> $past(brctl_word[BRCTL_VGA_BIT]));

    // R11
    io_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_win == WIN_IO) |-> ($past(req_space) == SP_IO));

    // R11
    rsvd_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(req_valid) && ($past(req_space) == SP_RSVD)) |-> !dec_fwd);

endmodule

// File: tb/bridge_window_decoder_tb.sv
`timescale 1ns/1ps
module bridge_window_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_space = 2'd0;
    logic [63:0] req_addr = '0;
    logic [15:0] cmd_word = '0;
    logic [15:0] brctl_word = '0;
    logic [7:0]  io_base_fld = 8'hF0;
    logic [7:0]  io_limit_fld = 8'h00;
    logic [15:0] io_base_hi = '0;
    logic [15:0] io_limit_hi = '0;
    logic [15:0] mem_base_fld = 16'hFFF0;
    logic [15:0] mem_limit_fld = 16'h0000;
    logic [15:0] pf_base_fld = 16'hFFF0;
    logic [15:0] pf_limit_fld = 16'h0000;
    logic [31:0] pf_base_hi = '0;
    logic [31:0] pf_limit_hi = '0;
    logic        dec_valid, dec_fwd;
    logic [2:0]  dec_win;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bridge_window_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_space(req_space),
        .req_addr(req_addr), .cmd_word(cmd_word), .brctl_word(brctl_word),
        .io_base_fld(io_base_fld), .io_limit_fld(io_limit_fld),
        .io_base_hi(io_base_hi), .io_limit_hi(io_limit_hi),
        .mem_base_fld(mem_base_fld), .mem_limit_fld(mem_limit_fld),
        .pf_base_fld(pf_base_fld), .pf_limit_fld(pf_limit_fld),
        .pf_base_hi(pf_base_hi), .pf_limit_hi(pf_limit_hi),
        .dec_valid(dec_valid), .dec_fwd(dec_fwd), .dec_win(dec_win)
    );

    localparam logic [1:0] S_IO = 2'd0, S_MEM = 2'd1, S_PF = 2'd2, S_RSV = 2'd3;

    task automatic clear_cfg();
        cmd_word = '0; brctl_word = '0;
        io_base_fld = 8'hF0; io_limit_fld = 8'h00; io_base_hi = '0; io_limit_hi = '0;
        mem_base_fld = 16'hFFF0; mem_limit_fld = 16'h0000;
        pf_base_fld = 16'hFFF0; pf_limit_fld = 16'h0000; pf_base_hi = '0; pf_limit_hi = '0;
    endtask

    task automatic probe(string tag, logic [1:0] sp, logic [63:0] a, logic ef, int ew);
        @(negedge clk);
        req_space = sp; req_addr = a; req_valid = 1'b1;
        @(negedge clk);
        checks++;
        if (dec_valid !== 1'b1 || dec_fwd !== ef || dec_win !== 3'(ew)) begin
            failures++;
            $display("FAIL %s addr=%h: valid=%b fwd=%b win=%0d expected valid=1 fwd=%b win=%0d",
                     tag, a, dec_valid, dec_fwd, dec_win, ef, ew);
        end
        req_valid = 1'b0;
    endtask

    task automatic expect_idle(string tag);
        checks++;
        if (dec_valid !== 1'b0 || dec_fwd !== 1'b0 || dec_win !== 3'd0) begin
            failures++;
            $display("FAIL %s: valid=%b fwd=%b win=%0d expected 0 0 0",
                     tag, dec_valid, dec_fwd, dec_win);
        end
    endtask

    task automatic t_reset();
        #1 expect_idle("R1 in reset");
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk); expect_idle("R1 after reset");
    endtask

    task automatic t_idle();
        clear_cfg(); cmd_word = 16'h0003; mem_base_fld = 16'h1000; mem_limit_fld = 16'h1000;
        probe("R2 hit", S_MEM, 64'h1000_0000, 1'b1, 2);
        @(negedge clk); expect_idle("R2 no request");
    endtask

    task automatic t_io16();
        clear_cfg(); cmd_word = 16'h0001;
        io_base_fld = 8'h20; io_limit_fld = 8'h30; io_base_hi = 16'h0001; io_limit_hi = 16'h0001;
        probe("R3 io low edge", S_IO, 64'h2000, 1'b1, 1);
        probe("R3 io high edge", S_IO, 64'h3FFF, 1'b1, 1);
        probe("R3 io below", S_IO, 64'h1FFF, 1'b0, 0);
        probe("R3 io above", S_IO, 64'h4000, 1'b0, 0);
        probe("R3 upper ignored", S_IO, 64'h1_2000, 1'b0, 0);
    endtask

    task automatic t_io32();
        clear_cfg(); cmd_word = 16'h0001;
        io_base_fld = 8'h21; io_limit_fld = 8'h31; io_base_hi = 16'h0001; io_limit_hi = 16'h0001;
        probe("R4 io32 base", S_IO, 64'h1_2000, 1'b1, 1);
        probe("R4 io32 limit", S_IO, 64'h1_3FFF, 1'b1, 1);
        probe("R4 io32 low alias", S_IO, 64'h2000, 1'b0, 0);
        probe("R4 io above 32b", S_IO, 64'h1_0001_2000, 1'b0, 0);
    endtask

    task automatic t_mem();
        clear_cfg(); cmd_word = 16'h0002;
        mem_base_fld = 16'h1230; mem_limit_fld = 16'h1240;
        probe("R5 mem base", S_MEM, 64'h1230_0000, 1'b1, 2);
        probe("R5 mem limit", S_MEM, 64'h124F_FFFF, 1'b1, 2);
        probe("R5 mem below", S_MEM, 64'h122F_FFFF, 1'b0, 0);
        probe("R5 mem above", S_MEM, 64'h1250_0000, 1'b0, 0);
        probe("R5 mem upper bits", S_MEM, 64'h1_1230_0000, 1'b0, 0);
    endtask

    task automatic t_pref();
        clear_cfg(); cmd_word = 16'h0002;
        pf_base_fld = 16'h4001; pf_limit_fld = 16'h4011; pf_base_hi = 32'h2; pf_limit_hi = 32'h2;
        probe("R6 pf64 base", S_PF, 64'h2_4000_0000, 1'b1, 3);
        probe("R6 pf64 limit", S_PF, 64'h2_401F_FFFF, 1'b1, 3);
        probe("R6 pf64 low alias", S_PF, 64'h4000_0000, 1'b0, 0);
        pf_base_fld = 16'h4000; pf_limit_fld = 16'h4010;
        probe("R6 pf32 hit", S_PF, 64'h4000_0000, 1'b1, 3);
        probe("R6 pf32 upper ignored", S_PF, 64'h2_4000_0000, 1'b0, 0);
    endtask

    task automatic t_empty();
        clear_cfg(); cmd_word = 16'h0003;
        mem_base_fld = 16'h2000; mem_limit_fld = 16'h1000;
        io_base_fld = 8'h50; io_limit_fld = 8'h40;
        probe("R7 mem empty at base", S_MEM, 64'h2000_0000, 1'b0, 0);
        probe("R7 mem empty at limit", S_MEM, 64'h1000_0000, 1'b0, 0);
        probe("R7 io empty", S_IO, 64'h5000, 1'b0, 0);
    endtask

    task automatic t_enables();
        clear_cfg();
        io_base_fld = 8'h20; io_limit_fld = 8'h30;
        mem_base_fld = 16'h1230; mem_limit_fld = 16'h1240;
        pf_base_fld = 16'h4000; pf_limit_fld = 16'h4010;
        probe("R8 io disabled", S_IO, 64'h2000, 1'b0, 0);
        probe("R8 mem disabled", S_MEM, 64'h1230_0000, 1'b0, 0);
        probe("R8 pf disabled", S_PF, 64'h4000_0000, 1'b0, 0);
        cmd_word = 16'h0002;
        probe("R8 io off mem on", S_IO, 64'h2000, 1'b0, 0);
        probe("R8 mem on", S_MEM, 64'h1230_0000, 1'b1, 2);
        cmd_word = 16'h0001;
        probe("R8 mem off io on", S_MEM, 64'h1230_0000, 1'b0, 0);
        probe("R8 io on", S_IO, 64'h2000, 1'b1, 1);
    endtask

    task automatic t_vga();
        clear_cfg(); brctl_word = 16'h0008;
        probe("R9 vga mem lo", S_MEM, 64'hA0000, 1'b1, 4);
        probe("R9 vga mem hi", S_MEM, 64'hBFFFF, 1'b1, 4);
        probe("R9 vga mem below", S_MEM, 64'h9FFFF, 1'b0, 0);
        probe("R9 vga mem above", S_MEM, 64'hC0000, 1'b0, 0);
        probe("R9 vga io 3B0", S_IO, 64'h3B0, 1'b1, 4);
        probe("R9 vga io 3BB", S_IO, 64'h3BB, 1'b1, 4);
        probe("R9 vga io gap 3BC", S_IO, 64'h3BC, 1'b0, 0);
        probe("R9 vga io 3C0", S_IO, 64'h3C0, 1'b1, 4);
        probe("R9 vga io 3DF", S_IO, 64'h3DF, 1'b1, 4);
        probe("R9 vga io 3E0", S_IO, 64'h3E0, 1'b0, 0);
        probe("R9 io addr as mem", S_MEM, 64'h3C0, 1'b0, 0);
        brctl_word = 16'h0000;
        probe("R9 vga off", S_MEM, 64'hA0000, 1'b0, 0);
    endtask

    task automatic t_priority();
        clear_cfg(); cmd_word = 16'h0003;
        mem_base_fld = 16'h1230; mem_limit_fld = 16'h1240;
        pf_base_fld = 16'h1230; pf_limit_fld = 16'h1240;
        probe("R10 pref over mem", S_MEM, 64'h1230_0000, 1'b1, 3);
        pf_base_fld = 16'hFFF0; pf_limit_fld = 16'h0000;
        mem_base_fld = 16'h0000; mem_limit_fld = 16'h0000;
        io_base_fld = 8'h00; io_limit_fld = 8'h00;
        brctl_word = 16'h0008;
        probe("R10 vga over mem", S_MEM, 64'hA0000, 1'b1, 4);
        probe("R10 mem outside vga", S_MEM, 64'h90000, 1'b1, 2);
        probe("R10 vga over io", S_IO, 64'h3C0, 1'b1, 4);
        probe("R10 io outside vga", S_IO, 64'h3BC, 1'b1, 1);
    endtask

    task automatic t_space();
        clear_cfg(); cmd_word = 16'h0003;
        mem_base_fld = 16'h1230; mem_limit_fld = 16'h1240;
        pf_base_fld = 16'h4000; pf_limit_fld = 16'h4010;
        probe("R11 reserved space", S_RSV, 64'h1230_0000, 1'b0, 0);
        probe("R11 mem req in pref", S_MEM, 64'h4000_0000, 1'b1, 3);
        probe("R11 pref req in mem", S_PF, 64'h1230_0000, 1'b1, 2);
        probe("R11 io req in mem", S_IO, 64'h1230_0000, 1'b0, 0);
        @(negedge clk); expect_idle("R12 none code after miss");
    endtask

    initial begin
        t_reset();
        t_idle();
        t_io16();
        t_io32();
        t_mem();
        t_pref();
        t_empty();
        t_enables();
        t_vga();
        t_priority();
        t_space();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule